// File: doc/BRIEF.md
# Key-Unlocked Serial Timekeeper Register Access Controller

This controller sits beside an SRAM on its bus-cycle path and decides, cycle by cycle, whether the SRAM or a bank of timekeeping registers owns the cycle. It receives one event per bus cycle. Each event carries a valid strobe, a read/write flag and data bit 0. Normally every cycle goes to memory. A read cycle arms a 64-bit key comparison. Each following write must present the next key bit on data bit 0. Once all 64 bits have matched, the controller claims the next 64 cycles and asserts a memory-inhibit output. During those cycles the eight 8-bit timekeeping registers are moved serially, one bit per cycle. A read cycle delivers a bit and a write cycle accepts a bit.

When the transfer starts, the controller takes a snapshot of all eight registers. Read cycles shift bits out of that snapshot, so the time they return stays self-consistent. Incoming bits are gathered per register. A register is written back only when all eight of its cycles were writes. An active-low abort input ends the transfer at once, with no partial register written, unless a reset-ignore control bit in the live register image is set. After the transfer completes or is aborted, the controller is locked again and needs a new read before it can recognise the key.

Top module: `kusc_top`

## Requirements
- R1: After reset, mem_inhibit_o and tk_wr_o are low and the controller is locked: a full key written with no read before it does not unlock.
- R2: A valid read cycle while no transfer is active sets the key pointer to bit 0. This also aborts any partly matched key, so recognition starts over from the next write.
- R3: The key is the 64-bit word 64'h5CA33AC55CA33AC5. Write number i after the arming read must carry key bit i on cyc_bit_i (bytes C5, 3A, A3, 5C repeated, least significant bit first). When write 63 matches, mem_inhibit_o is high from the next cycle.
- R4: A write whose bit differs from the current key bit locks the matcher. All later writes are then ignored until the next read.
- R5: Every cycle before the full match belongs to memory: mem_inhibit_o stays low through the cycle of the 64th key write.
- R6: A transfer consumes exactly 64 valid cycles. mem_inhibit_o is high from the cycle after the match through the cycle of the 64th transfer event, and low after it. Transfer position p = 8*r + b is bit b of register r, and register r occupies tk_regs_i[8r+7:8r].
- R7: During a read event at position p, rd_bit_o shows bit p of the register image captured in the matching cycle. Later changes on tk_regs_i do not affect it.
- R8: tk_wr_o pulses one cycle after the last bit of register r, with tk_wr_sel_o = r and tk_wr_byte_o holding the received bits (first bit in bit 0). This happens only if all eight cycles of that register were writes.
- R9: abort_ni low during a transfer while tk_regs_i[36] (register 4, bit 4) is 0 ends the transfer. mem_inhibit_o is low the next cycle, and nothing is written back, including a register whose last bit arrives in that same cycle.
- R10: abort_ni has no effect while tk_regs_i[36] is 1, and no effect outside a transfer.
- R11: After a transfer completes or is aborted, the controller is locked and needs a read before a key is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_valid_i | input | 1 | One bus cycle occurs this clock |
| cyc_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_bit_i | input | 1 | Data bit 0 of the cycle |
| abort_ni | input | 1 | Active-low transfer abort |
| tk_regs_i | input | 64 | Live image of the eight timekeeping registers |
| mem_inhibit_o | output | 1 | Cycle belongs to the register transfer, not memory |
| rd_bit_o | output | 1 | Bit presented to a read during transfer |
| tk_wr_o | output | 1 | Register write-back strobe |
| tk_wr_sel_o | output | 3 | Register index written |
| tk_wr_byte_o | output | 8 | Register value written |

## Verification
Two functions can fall in the same cycle: the abort and the eighth bit of a register, which would otherwise commit it. The bench drives abort_ni low in the very clock that carries bit 7 of register 1, after register 0 has committed normally. The scoreboard then expects only the register 0 write and must see no strobe for register 1. A second case also mixes two functions: a single read inside register 2 during an all-write transfer. For that transfer the queue must hold seven commits, with register 2 absent.

// File: rtl/kusc_pkg.sv
package kusc_pkg;
  localparam int unsigned KEY_BITS = 64;
  localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA33AC5_5CA33AC5;
endpackage

// File: rtl/kusc_key_matcher.sv
module kusc_key_matcher #(
  parameter int unsigned           KEY_W = 64,
  parameter logic [KEY_W-1:0]      KEY   = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_valid_i,
  input  logic evt_write_i,
  input  logic evt_bit_i,
  input  logic busy_i,
  output logic hit_o
);
  localparam int unsigned PW = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam logic [PW-1:0] LAST = PW'(KEY_W - 1);

  logic          armed_q;
  logic [PW-1:0] ptr_q;
  logic          evt, match;

  assign evt   = evt_valid_i && !busy_i;
  assign match = armed_q && evt_write_i && (evt_bit_i == KEY[ptr_q]);
  assign hit_o = evt && match && (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ptr_q   <= '0;
    end else if (evt) begin
      if (!evt_write_i) begin
        armed_q <= 1'b1;          // read arms / restarts
        ptr_q   <= '0;
      end else if (armed_q) begin
        if (match) begin
          if (ptr_q == LAST) begin
            armed_q <= 1'b0;
            ptr_q   <= '0;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end else begin
          armed_q <= 1'b0;        // mismatch locks out
        end
      end
    end
  end
endmodule

// File: rtl/kusc_xfer_engine.sv
module kusc_xfer_engine #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned REG_W = 8,
  localparam int unsigned XB   = NREG * REG_W,
  localparam int unsigned SW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XB-1:0]    regs_i,
  input  logic             evt_valid_i,
  input  logic             evt_write_i,
  input  logic             evt_bit_i,
  input  logic             abort_i,
  output logic             active_o,
  output logic             rd_bit_o,
  output logic             wr_o,
  output logic [SW-1:0]    wr_sel_o,
  output logic [REG_W-1:0] wr_byte_o
);
  localparam int unsigned PW = $clog2(XB);
  localparam int unsigned BW = (REG_W > 1) ? $clog2(REG_W) : 1;

  logic             active_q;
  logic [PW-1:0]    pos_q;
  logic [XB-1:0]    shadow_q;
  logic [REG_W-1:0] asm_q, asm_n;
  logic             wr_ok_q, wr_ok_n;
  logic [BW-1:0]    bit_idx;
  logic [SW-1:0]    reg_idx;
  logic             last_bit;

  // position = register index : bit index (REG_W a power of two)
  assign bit_idx  = pos_q[BW-1:0];
  assign reg_idx  = SW'(pos_q >> BW);
  assign last_bit = (bit_idx == BW'(REG_W - 1));

  always_comb begin
    asm_n          = asm_q;
    asm_n[bit_idx] = evt_bit_i;
    wr_ok_n        = ((bit_idx == '0) ? 1'b1 : wr_ok_q) & evt_write_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      pos_q     <= '0;
      shadow_q  <= '0;
      asm_q     <= '0;
      wr_ok_q   <= 1'b0;
      wr_o      <= 1'b0;
      wr_sel_o  <= '0;
      wr_byte_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          pos_q    <= '0;
          shadow_q <= regs_i;
          wr_ok_q  <= 1'b1;
        end
      end else if (abort_i) begin
        active_q <= 1'b0;         // partial register discarded
      end else if (evt_valid_i) begin
        pos_q   <= pos_q + 1'b1;
        wr_ok_q <= wr_ok_n;
        if (evt_write_i) asm_q <= asm_n;
        if (last_bit && wr_ok_n) begin
          wr_o      <= 1'b1;
          wr_sel_o  <= reg_idx;
          wr_byte_o <= asm_n;
        end
        if (pos_q == PW'(XB - 1)) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign rd_bit_o = active_q & shadow_q[pos_q];
endmodule

// File: rtl/kusc_top.sv
module kusc_top #(
  parameter int unsigned NREG        = 8,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned RST_IGN_REG = 4,
  parameter int unsigned RST_IGN_BIT = 4,
  localparam int unsigned XB         = NREG * REG_W,
  localparam int unsigned SW         = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_valid_i,
  input  logic             cyc_write_i,
  input  logic             cyc_bit_i,
  input  logic             abort_ni,
  input  logic [XB-1:0]    tk_regs_i,
  output logic             mem_inhibit_o,
  output logic             rd_bit_o,
  output logic             tk_wr_o,
  output logic [SW-1:0]    tk_wr_sel_o,
  output logic [REG_W-1:0] tk_wr_byte_o
);
  localparam int unsigned IGN_POS = RST_IGN_REG * REG_W + RST_IGN_BIT;

  logic hit, active, abort_req;

  assign abort_req = !abort_ni && !tk_regs_i[IGN_POS];

  kusc_key_matcher #(
    .KEY_W (kusc_pkg::KEY_BITS),
    .KEY   (kusc_pkg::UNLOCK_KEY)
  ) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (cyc_valid_i),
    .evt_write_i (cyc_write_i),
    .evt_bit_i   (cyc_bit_i),
    .busy_i      (active),
    .hit_o       (hit)
  );

  kusc_xfer_engine #(
    .NREG  (NREG),
    .REG_W (REG_W)
  ) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (hit),
    .regs_i      (tk_regs_i),
    .evt_valid_i (cyc_valid_i),
    .evt_write_i (cyc_write_i),
    .evt_bit_i   (cyc_bit_i),
    .abort_i     (abort_req),
    .active_o    (active),
    .rd_bit_o    (rd_bit_o),
    .wr_o        (tk_wr_o),
    .wr_sel_o    (tk_wr_sel_o),
    .wr_byte_o   (tk_wr_byte_o)
  );

  assign mem_inhibit_o = active;
endmodule

// File: rtl/kusc_checker.sv
module kusc_checker #(
  parameter int unsigned XB      = 64,
  parameter int unsigned IGN_POS = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cyc_valid_i,
  input logic          cyc_write_i,
  input logic          abort_ni,
  input logic [XB-1:0] tk_regs_i,
  input logic          mem_inhibit_o,
  input logic          tk_wr_o
);
  logic [7:0] evt_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             evt_cnt_q <= '0;
    else if (!mem_inhibit_o) evt_cnt_q <= '0;
    else if (cyc_valid_i)    evt_cnt_q <= evt_cnt_q + 1'b1;
  end

  // R6: never more than the transfer length inside one inhibit window
  a_r6_xfer_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt_q <= 8'(XB));

  // R5: inhibit rises only after a write cycle
  a_r5_rise_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_inhibit_o) |-> $past(cyc_valid_i && cyc_write_i));

  // R8: write-back only from inside a transfer
  a_r8_wr_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_wr_o |-> $past(mem_inhibit_o));

  // R9: enabled abort ends transfer with no commit
  a_r9_abort_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_inhibit_o && !abort_ni && !tk_regs_i[IGN_POS]) |=> (!mem_inhibit_o && !tk_wr_o));

  // R11: no immediate re-entry after a transfer ends
  a_r11_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_inhibit_o) |=> !mem_inhibit_o);
endmodule

bind kusc_top kusc_checker #(.XB(XB), .IGN_POS(IGN_POS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cyc_valid_i   (cyc_valid_i),
  .cyc_write_i   (cyc_write_i),
  .abort_ni      (abort_ni),
  .tk_regs_i     (tk_regs_i),
  .mem_inhibit_o (mem_inhibit_o),
  .tk_wr_o       (tk_wr_o)
);

// File: tb/kusc_tb_top.sv
`timescale 1ns/1ps
module kusc_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        v = 0, w = 0, b = 0, ab_n = 1;
  logic [63:0] regs = '0;
  logic        inh, rdb, wr;
  logic [2:0]  sel;
  logic [7:0]  byt;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [10:0] exp_q[$];   // {sel, byte}
  logic [63:0] key;

  always #2 clk = ~clk;    // 250 MHz

  kusc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_valid_i(v), .cyc_write_i(w), .cyc_bit_i(b),
    .abort_ni(ab_n), .tk_regs_i(regs), .mem_inhibit_o(inh), .rd_bit_o(rdb),
    .tk_wr_o(wr), .tk_wr_sel_o(sel), .tk_wr_byte_o(byt));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected commits
  always @(negedge clk) if (rst_n && wr) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R8 actual=%0h expected=none", {sel, byt});
    end else begin
      logic [10:0] e;
      e = exp_q.pop_front();
      if (e !== {sel, byt}) begin
        errors++;
        $display("FAIL R8 actual=%0h expected=%0h", {sel, byt}, e);
      end
    end
  end

  task automatic cyc(input logic wi, input logic bi);
    @(negedge clk); v = 1; w = wi; b = bi;
    @(negedge clk); v = 0;
    #0.5;
  endtask

  task automatic send_key(input string req);
    for (int i = 0; i < 64; i++) begin
      chk(req, inh, 0);
      cyc(1, key[i]);
    end
  endtask

  initial begin
    key = '0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] kb;
      case (i % 4) 0: kb = 8'hC5; 1: kb = 8'h3A; 2: kb = 8'hA3; default: kb = 8'h5C; endcase
      key[i*8 +: 8] = kb;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset inhibit", inh, 0);
    chk("R1 reset wr", wr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #0.5;

    // R1: key without arming read
    send_key("R5");
    chk("R1 locked after reset", inh, 0);

    // R2/R3/R5: arm and unlock
    cyc(0, 0);
    send_key("R5 before match");
    chk("R3 unlocked", inh, 1);

    // R6/R7: read transfer from snapshot, live regs changed
    regs = 64'h0123_4567_89AB_CDEF;
    begin
      logic [63:0] snap;
      snap = 64'h0;     // regs were 0 at the match cycle
      regs = 64'hFFFF_FFFF_FFFF_FFFF & 64'h0123_4567_89AB_CDEF;
      for (int p = 0; p < 64; p++) begin
        @(negedge clk); v = 1; w = 0; b = 0;
        #0.5;
        if (p == 5 || p == 40) chk("R7 snapshot bit", rdb, snap[p]);
        if (p == 63) chk("R6 inhibit at last", inh, 1);
        @(negedge clk); v = 0;
        #0.5;
      end
      chk("R6 end of transfer", inh, 0);
    end

    // R11: key right after transfer without read
    send_key("R11 relock");
    chk("R11 needs read", inh, 0);

    // R7 with nonzero snapshot
    regs = 64'hA5C3_1E0F_7B26_D948;
    cyc(0, 0);
    send_key("R5");
    regs = 64'h0;
    chk("R3 unlock 2", inh, 1);
    for (int p = 0; p < 64; p++) begin
      @(negedge clk); v = 1; w = 0; b = 0;
      #0.5;
      if (p % 9 == 0) chk("R7 shadow out", rdb, regs[p] ^ 64'hA5C3_1E0F_7B26_D948 >> p & 1);
      @(negedge clk); v = 0;
      #0.5;
    end
    chk("R6 done 2", inh, 0);

    // R4: mismatch then rest of key -> no unlock
    cyc(0, 0);
    for (int i = 0; i < 64; i++) cyc(1, (i == 10) ? ~key[i] : key[i]);
    chk("R4 mismatch locks", inh, 0);
    send_key("R4 ignored writes");
    chk("R4 still locked", inh, 0);

    // R2: read mid-recognition restarts
    cyc(0, 0);
    for (int i = 0; i < 30; i++) cyc(1, key[i]);
    cyc(0, 0);
    send_key("R2");
    chk("R2 restart unlocks", inh, 1);

    // R8/R10: full write transfer with ignored abort (bit36 = 1)
    regs = 64'h0000_0010_0000_0000;
    begin
      logic [63:0] dat;
      dat = 64'h1122_3344_5566_7788;
      for (int r = 0; r < 8; r++) exp_q.push_back({3'(r), dat[r*8 +: 8]});
      for (int p = 0; p < 64; p++) begin
        @(negedge clk); v = 1; w = 1; b = dat[p];
        ab_n = (p >= 20 && p < 30) ? 1'b0 : 1'b1;
        @(negedge clk); v = 0; ab_n = 1;
        #0.5;
        if (p == 30) chk("R10 abort ignored", inh, 1);
      end
      chk("R6 end write", inh, 0);
      chk("R8 all commits", exp_q.size(), 0);
    end

    // R10: abort outside transfer no effect
    regs = 64'h0;
    ab_n = 0;
    cyc(0, 0);
    send_key("R10");
    ab_n = 1;
    // abort was low until now but transfer just starting: check unlocked
    chk("R10 abort outside xfer", inh, 1);

    // R8: one read in register 2 -> register 2 not committed
    begin
      logic [63:0] dat;
      dat = 64'hF0E1_D2C3_B4A5_9687;
      for (int r = 0; r < 8; r++) if (r != 2) exp_q.push_back({3'(r), dat[r*8 +: 8]});
      for (int p = 0; p < 64; p++) cyc((p == 17) ? 1'b0 : 1'b1, dat[p]);
      chk("R8 mixed register skipped", exp_q.size(), 0);
    end

    // R9: abort with partial register 2
    cyc(0, 0);
    send_key("R9");
    begin
      logic [63:0] dat;
      dat = 64'h0000_0000_00AB_CDEF;
      exp_q.push_back({3'd0, dat[7:0]});
      exp_q.push_back({3'd1, dat[15:8]});
      for (int p = 0; p < 20; p++) cyc(1, dat[p]);
      @(negedge clk); ab_n = 0;
      @(negedge clk); ab_n = 1;
      #0.5;
      chk("R9 abort drops inhibit", inh, 0);
      for (int p = 0; p < 8; p++) cyc(1, 1'b1);
      chk("R9 no partial commit", exp_q.size(), 0);
      send_key("R11 after abort");
      chk("R11 after abort locked", inh, 0);
    end

    // R9: abort in same cycle as last bit of register 1
    cyc(0, 0);
    send_key("R9");
    exp_q.push_back({3'd0, 8'h5A});
    for (int p = 0; p < 15; p++) cyc(1, (p < 8) ? 8'h5A >> p & 1 : 1'b1);
    @(negedge clk); v = 1; w = 1; b = 1; ab_n = 0;
    @(negedge clk); v = 0; ab_n = 1;
    #0.5;
    chk("R9 collision inhibit", inh, 0);
    repeat (3) @(negedge clk);
    chk("R9 collision no commit", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule